// File: doc/BRIEF.md
# Rotational Ternary Pattern Matcher

This block takes a reference pattern and a candidate pattern, both WIDTH positions long and both three-valued: each position is 0, 1 or don't-care. It looks for the smallest cyclic rotation of the reference that lines up with the candidate. A rotation counts as a match in either of two ways. The first is plain agreement. The second is full complement, where every specified position has the opposite value.

A single-cycle start strobe captures both patterns. The block then checks one rotation per clock, starting at a shift of one. It stops at the first rotation that qualifies, or after the last rotation fails. The result stays on the outputs until the next accepted start. A tool that builds chains of test stimuli uses it to learn how far a loaded stimulus must be cycled around a closed scan ring before it can stand in for another stimulus.

Top module: `rot_ternary_match`

## Requirements
- R1: A trial at shift n compares candidate position k with reference position (k+n) mod WIDTH. Bit index 0 is the least significant bit of each vector.
- R2: The shifts tried are 1 through WIDTH-1, in increasing order. Shift 0 is never tried, so a pair that lines up only at shift 0 gives found=0.
- R3: A position whose care bit is 0 on either side (care=1 means specified) neither conflicts nor agrees.
- R4: A shift is a direct match when no position has both sides specified with different values. It is then reported with inverted=0.
- R5: A shift is a complement match when no position has both sides specified with equal values. It is then reported with inverted=1.
- R6: The smallest qualifying shift is reported. When a shift is both a direct and a complement match, inverted=0.
- R7: With the start taken at clock edge 0, a hit at shift n raises done after edge n, with found=1 and shift_amt=n. A miss raises done after edge WIDTH-1, with found=0, shift_amt=0 and inverted=0.
- R8: A start that arrives while a search is running is ignored. Neither the operands nor the running search change.
- R9: An accepted start clears done, found, shift_amt and inverted at the next edge. Between searches the outputs hold their values, whatever the inputs do.
- R10: A synchronous active-high reset clears done, found, shift_amt and inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted only while idle |
| ref_val | input | WIDTH | Reference values |
| ref_care | input | WIDTH | Reference care mask (1 = specified) |
| cand_val | input | WIDTH | Candidate values |
| cand_care | input | WIDTH | Candidate care mask (1 = specified) |
| done | output | 1 | Search finished, result valid |
| found | output | 1 | A qualifying shift exists |
| shift_amt | output | $clog2(WIDTH) | Smallest qualifying shift |
| inverted | output | 1 | Result is a complement match |

## Verification
The hardest situations to reach from the ports are a stray start in the middle of a running search and a rotation that is a direct match and a complement match at once. For the first, the bench issues a second start two cycles into a long search. The second start carries operands that would hit at once, and the bench then confirms that the original latency and result stand. For the second, the bench makes the reference entirely don't-care, so that the first rotation qualifies both ways. A candidate that is only the unrotated reference confirms that shift 0 is never tried. A don't-care placed on the candidate turns a miss into a hit at the last shift.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_SCAN = 1'b1} scan_state_t;
endpackage

// File: rtl/rtm_ring.sv
// Rotating copy of the reference pattern: load stores it pre-rotated by one,
// step rotates it one more position (position k takes old position k+1).
module rtm_ring #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] in_val,
  input  logic [WIDTH-1:0] in_care,
  output logic [WIDTH-1:0] rot_val,
  output logic [WIDTH-1:0] rot_care
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rot_val  <= '0;
      rot_care <= '0;
    end else if (load) begin
      rot_val  <= {in_val[0], in_val[WIDTH-1:1]};
      rot_care <= {in_care[0], in_care[WIDTH-1:1]};
    end else if (step) begin
      rot_val  <= {rot_val[0], rot_val[WIDTH-1:1]};
      rot_care <= {rot_care[0], rot_care[WIDTH-1:1]};
    end
  end

  // R1: rotation preserves the number of ones in the value and mask
  a_r1_rotate_keeps_weight: assert property (@(posedge clk) disable iff (rst)
    step && !load |=> ($countones(rot_val) == $countones($past(rot_val)))
                   && ($countones(rot_care) == $countones($past(rot_care))));
endmodule

// File: rtl/rtm_cmp.sv
// Per-position ternary comparison of one rotation against the candidate.
module rtm_cmp #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_val,
  input  logic [WIDTH-1:0] a_care,
  input  logic [WIDTH-1:0] b_val,
  input  logic [WIDTH-1:0] b_care,
  output logic             direct_ok,
  output logic             compl_ok
);
  logic [WIDTH-1:0] clash;
  logic [WIDTH-1:0] same;

  for (genvar k = 0; k < WIDTH; k++) begin : g_pos
    logic both;
    assign both     = a_care[k] & b_care[k];
    assign clash[k] = both & (a_val[k] ^ b_val[k]);
    assign same[k]  = both & ~(a_val[k] ^ b_val[k]);
  end

  assign direct_ok = ~|clash;
  assign compl_ok  = ~|same;
endmodule

// File: rtl/rtm_ctrl.sv
// Search sequencer and result registers.
module rtm_ctrl
  import rtm_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int CW = $clog2(WIDTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          direct_ok,
  input  logic          compl_ok,
  output logic          load,
  output logic          step,
  output logic          done,
  output logic          found,
  output logic [CW-1:0] shift_amt,
  output logic          inverted
);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  scan_state_t   state;
  logic [CW-1:0] trial;
  logic          hit;
  logic          busy;

  assign busy = (state == ST_SCAN);
  assign hit  = direct_ok | compl_ok;
  assign load = start & ~busy;
  assign step = busy & ~hit & (trial != LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      trial     <= '0;
      done      <= 1'b0;
      found     <= 1'b0;
      shift_amt <= '0;
      inverted  <= 1'b0;
    end else if (load) begin
      state     <= ST_SCAN;
      trial     <= CW'(1);
      done      <= 1'b0;
      found     <= 1'b0;
      shift_amt <= '0;
      inverted  <= 1'b0;
    end else if (busy) begin
      if (hit) begin
        state     <= ST_IDLE;
        done      <= 1'b1;
        found     <= 1'b1;
        shift_amt <= trial;
        inverted  <= ~direct_ok;
      end else if (trial == LAST) begin
        state <= ST_IDLE;
        done  <= 1'b1;
      end else begin
        trial <= trial + CW'(1);
      end
    end
  end

  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
  a_r2_shift_nonzero: assert property (@(posedge clk) disable iff (rst)
    found |-> (shift_amt != '0) && done);
  a_r5_inverted_needs_found: assert property (@(posedge clk) disable iff (rst)
    inverted |-> found);
  a_r9_start_clears: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy && !done && !found);
  a_r9_result_held: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done && $stable(found) && $stable(shift_amt) && $stable(inverted));
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    busy && start && !hit && (trial != LAST) |=> busy && (trial == $past(trial) + CW'(1)));
endmodule

// File: rtl/rot_ternary_match.sv
module rot_ternary_match #(
  parameter int WIDTH = 16,
  localparam int CW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] ref_val,
  input  logic [WIDTH-1:0] ref_care,
  input  logic [WIDTH-1:0] cand_val,
  input  logic [WIDTH-1:0] cand_care,
  output logic             done,
  output logic             found,
  output logic [CW-1:0]    shift_amt,
  output logic             inverted
);
  logic             load, step, direct_ok, compl_ok;
  logic [WIDTH-1:0] rot_val, rot_care, cv_q, cc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cv_q <= '0;
      cc_q <= '0;
    end else if (load) begin
      cv_q <= cand_val;
      cc_q <= cand_care;
    end
  end

  rtm_ring #(.WIDTH(WIDTH)) u_ring (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .in_val(ref_val), .in_care(ref_care),
    .rot_val(rot_val), .rot_care(rot_care));

  rtm_cmp #(.WIDTH(WIDTH)) u_cmp (
    .a_val(rot_val), .a_care(rot_care), .b_val(cv_q), .b_care(cc_q),
    .direct_ok(direct_ok), .compl_ok(compl_ok));

  rtm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .direct_ok(direct_ok), .compl_ok(compl_ok),
    .load(load), .step(step), .done(done), .found(found),
    .shift_amt(shift_amt), .inverted(inverted));
endmodule

// File: tb/test_rot_ternary_match.sv
module test_rot_ternary_match;
  localparam int W  = 8;
  localparam int CW = $clog2(W);
  localparam int NV = 8;

  // vectors: ref value, ref care, cand value, cand care, found, shift, inverted
  localparam logic [7:0] T_RV [NV] = '{8'h01, 8'h01, 8'h01, 8'h03, 8'h01, 8'h03, 8'h00, 8'h55};
  localparam logic [7:0] T_RC [NV] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF};
  localparam logic [7:0] T_CV [NV] = '{8'h80, 8'h04, 8'h7F, 8'h05, 8'h01, 8'h04, 8'h5A, 8'h55};
  localparam logic [7:0] T_CC [NV] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFD, 8'hFF, 8'hFF};
  localparam logic       T_F  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam int         T_N  [NV] = '{1, 6, 1, 0, 0, 7, 1, 1};
  localparam logic       T_I  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [W-1:0] ref_val = '0, ref_care = '0, cand_val = '0, cand_care = '0;
  logic done, found, inverted;
  logic [CW-1:0] shift_amt;
  int checks = 0, errors = 0, cyc;

  always #4 clk = ~clk;

  rot_ternary_match #(.WIDTH(W)) i_rot_ternary_match (
    .clk(clk), .rst(rst), .start(start), .ref_val(ref_val), .ref_care(ref_care),
    .cand_val(cand_val), .cand_care(cand_care), .done(done), .found(found),
    .shift_amt(shift_amt), .inverted(inverted));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick(input logic [W-1:0] rv, rc, cv, cc);
    @(negedge clk);
    ref_val = rv; ref_care = rc; cand_val = cv; cand_care = cc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
  endtask

  task automatic wait_done();
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10 done", int'(done), 0);
    check("R10 found", int'(found), 0);
    check("R10 shift", int'(shift_amt), 0);
    check("R10 inverted", int'(inverted), 0);

    // table walk: R1 R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      kick(T_RV[v], T_RC[v], T_CV[v], T_CC[v]);
      check($sformatf("R9 done cleared v%0d", v), int'(done), 0);
      wait_done();
      check($sformatf("R7 latency v%0d", v), cyc, T_F[v] ? T_N[v] : W - 1);
      check($sformatf("R4 R5 found v%0d", v), int'(found), int'(T_F[v]));
      check($sformatf("R1 R6 shift v%0d", v), int'(shift_amt), T_N[v]);
      check($sformatf("R5 R6 inverted v%0d", v), int'(inverted), int'(T_I[v]));
    end

    // R9: result held while inputs change and no start is given
    ref_val = 8'hAA; cand_val = 8'h33; ref_care = 8'hF0; cand_care = 8'h0F;
    repeat (5) @(negedge clk);
    check("R9 hold done", int'(done), 1);
    check("R9 hold found", int'(found), 1);
    check("R9 hold shift", int'(shift_amt), 1);
    check("R9 hold inverted", int'(inverted), 1);

    // R8: second start during a shift-6 search with operands that hit at shift 1
    kick(8'h01, 8'hFF, 8'h04, 8'hFF);
    @(negedge clk); cyc++;
    ref_val = 8'h01; cand_val = 8'h80; start = 1'b1;
    @(negedge clk); cyc++;
    start = 1'b0;
    check("R8 still busy", int'(done), 0);
    wait_done();
    check("R8 latency", cyc, 6);
    check("R8 shift", int'(shift_amt), 6);
    check("R8 found", int'(found), 1);

    // R10: reset mid-result
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 reset clears done", int'(done), 0);
    check("R10 reset clears shift", int'(shift_amt), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule